// File: doc/BRIEF.md
# Carry-Pipelined Timestamp Counter

This block is a free-running binary counter built to close timing at very high clock rates. No carry chain runs through it. Each bit position has its own registered carry. Bit i toggles when the carry register feeding it is high, and the carry passed upward is the AND of that carry and the bit. Only one gate of carry logic therefore sits between any two flops, and the reachable clock rate does not depend on the width. The cost is that the raw count is skewed: each bit lags the bit below it by one clock.

A snapshot request reads the count. Software or a slower reader pulses `capture_req`. The block delays that strobe by i clocks before it samples bit i, which undoes the skew. All captured bits then describe the same logical count. The result is held in a snapshot register, and a valid flag tells the reader that every bit has arrived. While a capture is still moving through the deskew pipeline, further requests are dropped.

Top module: `tsc_timestamp_counter`

## Requirements
- R1: In the first cycle after a synchronous reset, `snap_valid` is 0 and `snap_value` is 0. A capture that is in flight when reset arrives is discarded, so `snap_valid` stays 0 afterwards.
- R2: Cycle 0 is the first cycle after reset is released, and the count advances by exactly one per cycle. If a request is sampled high at the end of cycle t, the resulting snapshot equals t modulo 2^WIDTH.
- R3: For a request accepted in cycle t, `snap_valid` is 0 in cycles t+1 through t+WIDTH-1 and is 1 in cycle t+WIDTH.
- R4: `snap_valid` falls in the cycle after a request is accepted. Otherwise `snap_valid` and `snap_value` hold until the next accepted request.
- R5: A request in cycles t+1 through t+WIDTH-1 after an accepted one has no effect. It changes neither the pending snapshot value nor the cycle in which `snap_valid` rises.
- R6: A request in cycle t+WIDTH is accepted. A request held high therefore yields snapshots every WIDTH cycles, carrying the values t, t+WIDTH, t+2·WIDTH, and so on.
- R7: The count wraps from all ones to zero. With WIDTH=6, a request in cycle 63 yields 6'h3F and a request in cycle 64 yields 6'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| capture_req | input | 1 | Snapshot request, sampled on each rising edge |
| snap_value | output | WIDTH | Deskewed snapshot of the count |
| snap_valid | output | 1 | High when all bits of `snap_value` belong to the last accepted request |

## Verification
Two functions can fall in the same cycle: presenting a finished snapshot, and accepting the next request. In cycle t+WIDTH the old snapshot is visible with `snap_valid` high, and a request in that same cycle must be taken. The bench provokes this with zero-gap rows in its vector table and with a request held high across three capture periods. It judges each case by checking that the old value is shown in that cycle, that `snap_valid` drops in the next cycle, and that the new value, equal to the reference count, appears WIDTH cycles later. A second collision, reset landing on an in-flight capture, is checked by requiring `snap_valid` to stay low afterwards.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Next state of a count bit given its registered carry-in.
  function automatic logic bit_next(input logic cur, input logic carry_in);
    return cur ^ carry_in;
  endfunction

  // Carry handed to the next higher position.
  function automatic logic carry_next(input logic cur, input logic carry_in);
    return cur & carry_in;
  endfunction

  // Snapshot flag update: set when the top bit lands, clear on a new accept.
  function automatic logic valid_next(input logic cur, input logic top_landing,
                                      input logic accepted);
    if (top_landing) return 1'b1;
    if (accepted)    return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/tsc_count_bit.sv
module tsc_count_bit (
  input  logic clk,
  input  logic rst,
  input  logic carry_in,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= tsc_pkg::bit_next(bit_q, carry_in);
  end
endmodule

// File: rtl/tsc_skew_counter.sv
module tsc_skew_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] skew_bits
);
  // chain[i] is the registered carry into bit i; the bit-0 carry is tied high
  logic [WIDTH-1:0] chain;
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    tsc_count_bit u_bit (
      .clk      (clk),
      .rst      (rst),
      .carry_in (chain[i]),
      .bit_q    (skew_bits[i])
    );
    if (i < WIDTH - 1) begin : g_carry
      always_ff @(posedge clk) begin
        if (rst) chain[i+1] <= 1'b0;
        else     chain[i+1] <= tsc_pkg::carry_next(skew_bits[i], chain[i]);
      end
    end
  end
endmodule

// File: rtl/tsc_deskew_capture.sv
module tsc_deskew_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_req,
  input  logic [WIDTH-1:0] skew_bits,
  output logic [WIDTH-1:0] snap_value,
  output logic             snap_valid,
  output logic             accept,
  output logic             busy,
  output logic [WIDTH-1:1] strobe_line
);
  assign busy   = |strobe_line;
  assign accept = capture_req & ~busy;

  // strobe_line[i] is the accepted strobe delayed by i clocks
  for (genvar i = 1; i < WIDTH; i++) begin : g_dly
    if (i == 1) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) strobe_line[i] <= 1'b0;
        else     strobe_line[i] <= accept;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) strobe_line[i] <= 1'b0;
        else     strobe_line[i] <= strobe_line[i-1];
      end
    end
  end

  // bit i is sampled when the strobe has aged i clocks, matching its lag
  for (genvar i = 0; i < WIDTH; i++) begin : g_snap
    logic take;
    if (i == 0) begin : g_lsb
      assign take = accept;
    end else begin : g_upper
      assign take = strobe_line[i];
    end
    always_ff @(posedge clk) begin
      if (rst)       snap_value[i] <= 1'b0;
      else if (take) snap_value[i] <= skew_bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) snap_valid <= 1'b0;
    else     snap_valid <= tsc_pkg::valid_next(snap_valid, strobe_line[WIDTH-1], accept);
  end
endmodule

// File: rtl/tsc_timestamp_counter.sv
module tsc_timestamp_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_req,
  output logic [WIDTH-1:0] snap_value,
  output logic             snap_valid
);
  if (WIDTH < 2) begin : g_bad_width
    $error("tsc_timestamp_counter needs WIDTH of at least 2");
  end

  // named internal events, visible to the bound checker
  logic [WIDTH-1:0] skew_bits;
  logic             accept;
  logic             busy;
  logic [WIDTH-1:1] strobe_line;

  tsc_skew_counter #(.WIDTH(WIDTH)) u_count (
    .clk       (clk),
    .rst       (rst),
    .skew_bits (skew_bits)
  );

  tsc_deskew_capture #(.WIDTH(WIDTH)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .capture_req (capture_req),
    .skew_bits   (skew_bits),
    .snap_value  (snap_value),
    .snap_valid  (snap_valid),
    .accept      (accept),
    .busy        (busy),
    .strobe_line (strobe_line)
  );
endmodule

// File: rtl/tsc_timestamp_checker.sv
module tsc_timestamp_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             skew_lsb,
  input logic             accept,
  input logic             busy,
  input logic [WIDTH-1:1] strobe_line,
  input logic [WIDTH-1:0] snap_value,
  input logic             snap_valid
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!snap_valid && snap_value == '0)); // R1

  AST_LSB_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (skew_lsb != $past(skew_lsb))); // R2

  AST_ACCEPT_STARTS_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy); // R3

  AST_VALID_AFTER_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    $rose(snap_valid) |-> $past(busy)); // R3

  AST_ACCEPT_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    accept |=> !snap_valid); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> ($stable(snap_value) && $stable(snap_valid))); // R4

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe_line)); // R5
endmodule

bind tsc_timestamp_counter tsc_timestamp_checker #(.WIDTH(WIDTH)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .skew_lsb    (skew_bits[0]),
  .accept      (accept),
  .busy        (busy),
  .strobe_line (strobe_line),
  .snap_value  (snap_value),
  .snap_valid  (snap_valid)
);

// File: tb/tsc_timestamp_counter_test.sv
module tsc_timestamp_counter_test;
  localparam int unsigned W  = 32;
  localparam int unsigned SW = 6;
  localparam int unsigned NV = 8;
  // idle cycles between the previous snapshot and the next request
  localparam int unsigned GAP_TABLE [NV] = '{0, 1, 2, 7, 31, 32, 33, 90};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_s = 1'b0;
  logic [W-1:0]  value;
  logic          valid;
  logic [SW-1:0] value_s;
  logic          valid_s;
  logic [W-1:0]  ref_cnt;
  logic [SW-1:0] ref_cnt_s;
  int            nchk = 0;
  int            nfail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  tsc_timestamp_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .capture_req(req), .snap_value(value), .snap_valid(valid));

  tsc_timestamp_counter #(.WIDTH(SW)) uut_small (
    .clk(clk), .rst(rst), .capture_req(req_s), .snap_value(value_s), .snap_valid(valid_s));

  // behavioural plain counters: value in cycle t is t
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt   <= '0;
      ref_cnt_s <= '0;
    end else begin
      ref_cnt   <= ref_cnt + 1'b1;
      ref_cnt_s <= ref_cnt_s + 1'b1;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request in the current cycle t; returns at cycle t+W
  task automatic capture_one(input string tag);
    logic [W-1:0] stamp;
    stamp = ref_cnt;
    req = 1'b1;
    step();
    req = 1'b0;
    chk(valid == 1'b0, {"R4 valid drops ", tag}, W'(valid), 0);
    repeat (W - 2) step();
    chk(valid == 1'b0, {"R3 early valid ", tag}, W'(valid), 0);
    step();
    chk(valid == 1'b1, {"R3 valid rise ", tag}, W'(valid), 1);
    chk(value == stamp, {"R2 value ", tag}, value, stamp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
  endtask

  initial begin
    logic [W-1:0] s0;
    bit ok;
    repeat (3) step();
    rst = 1'b0;
    chk(valid == 1'b0, "R1 reset valid", W'(valid), 0);
    chk(value == '0, "R1 reset value", value, 0);

    // vector table; a zero gap lands the request on the valid cycle (R6)
    for (int v = 0; v < NV; v++) begin
      repeat (GAP_TABLE[v]) step();
      capture_one($sformatf("vector %0d", v));
    end

    // R5: extra request while in flight is ignored
    repeat (3) step();
    s0 = ref_cnt;
    req = 1'b1; step(); req = 1'b0;
    step(); step();
    req = 1'b1; step(); req = 1'b0;
    repeat (W - 5) step();
    chk(valid == 1'b0, "R5 valid not early", W'(valid), 0);
    step();
    chk(valid == 1'b1, "R5 valid on time", W'(valid), 1);
    chk(value == s0, "R5 value from first request", value, s0);
    ok = 1'b1;
    for (int k = 0; k < int'(W) + 4; k++) begin
      step();
      if (!valid || value != s0) ok = 1'b0;
    end
    chk(ok, "R4 snapshot held", value, s0);

    // R6: request held high gives a snapshot every W cycles
    s0 = ref_cnt;
    req = 1'b1;
    for (int c = 1; c <= 3 * int'(W); c++) begin
      step();
      if (c % int'(W) == 0) begin
        chk(valid == 1'b1, "R6 periodic valid", W'(valid), 1);
        chk(value == s0 + W'(c) - W, "R6 periodic value", value, s0 + W'(c) - W);
      end else if (c % int'(W) == 1) begin
        chk(valid == 1'b0, "R6 valid drop", W'(valid), 0);
      end
    end
    req = 1'b0;
    repeat (W + 2) step();

    // R1: reset cancels an in-flight capture
    req = 1'b1; step(); req = 1'b0;
    step(); step();
    do_reset();
    chk(valid == 1'b0 && value == '0, "R1 reset mid-flight", value, 0);
    repeat (W + 2) step();
    chk(valid == 1'b0, "R1 cancelled capture stays invalid", W'(valid), 0);

    // R7: rollover on the narrow instance
    do_reset();
    repeat (63) step();
    req_s = 1'b1; step(); req_s = 1'b0;
    repeat (SW - 1) step();
    chk(valid_s == 1'b1 && value_s == 6'h3F, "R7 all ones", W'(value_s), 32'h3F);
    do_reset();
    repeat (64) step();
    req_s = 1'b1; step(); req_s = 1'b0;
    repeat (SW - 1) step();
    chk(valid_s == 1'b1 && value_s == 6'h00, "R7 wrap to zero", W'(value_s), 0);
    repeat (63) step();
    req_s = 1'b1; step(); req_s = 1'b0;
    repeat (SW - 1) step();
    chk(valid_s == 1'b1 && value_s == ref_cnt_s - 6'(SW), "R7 second wrap", W'(value_s),
        W'(ref_cnt_s - 6'(SW)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule